// File: doc/BRIEF.md
# Level-Sensed DMA Request Front End with Block Sequencer

This block takes an active-low external transfer request for one DMA channel and turns it into whole block transfers. Software opens the channel with a single configuration write that carries a block count and a block length. From the next clock edge on, the block samples its synchronized request input on every rising edge. A low level seen while the channel is accepting becomes one pending request. The pending request is held through a short clearance interval, and then the block asks for the bus. Once granted, it runs one block: an alternating series of source read cycles and destination write cycles. It then releases the bus for one dead cycle and reopens acceptance.

The sequence of sampling, holding, activating, transferring and resuming repeats once per block until the programmed number of blocks has been moved. At that point the channel closes itself and raises a one-cycle completion flag. A disable write can close the channel at any time. A block that is already pending or running still completes, but no new request is accepted.

The sequencer has six states. IDLE accepts requests. HOLD keeps the pending request during clearance. BUSREQ waits for the grant. READ and WRITE alternate for each transfer. DEAD is the idle cycle in which the bus is released. The transitions are:
- latch: IDLE to HOLD, when the channel is open and the synchronized request is low.
- activate: HOLD to BUSREQ, after two HOLD cycles.
- granted: BUSREQ to READ.
- pair: READ to WRITE.
- next: WRITE to READ, while transfers remain in the block.
- last: WRITE to DEAD, on the final transfer.
- reopen: DEAD to IDLE.

Top module: `dreq_accept`

## Requirements
- R1: A write with `cfg_wr`=1 and `cfg_enable`=1 takes effect only while the sequencer is idle and `cfg_blocks` is nonzero. It loads the block count and length and opens the channel, and the request input is first sampled on the edge after that write. An enabling write with `cfg_blocks`=0, or one made while a block is pending or running, has no effect.
- R2: The request pin passes through a two-flop synchronizer. A low level first driven before rising edge 1 is latched at edge 3 if the channel is accepting.
- R3: A latched request is held for two cycles (clearance) and then `bus_req` rises. With the grant already given, the first read cycle follows one cycle later, so at least three cycles separate the latch from the first read.
- R4: While a request is pending or a block is in progress, low levels on the pin are ignored and not queued. At most one request is pending at a time.
- R5: A block whose length field is L performs L+1 transfers. Each transfer is one `rd_cyc` cycle followed directly by one `wr_cyc` cycle, and `bus_req` stays high from the request until the last write.
- R6: The cycle after the last write of a block is a dead cycle with `bus_req` low. The pin is sampled again on the edge that ends the following idle cycle. With the request held low and an immediate grant, the next read comes 6 cycles after the last write, or 6+g cycles when the grant lags g cycles.
- R7: Each block decrements the block count in its dead cycle. When the count reaches zero, the channel closes and `done` is high for exactly one cycle, the cycle after that dead cycle. No block starts after that.
- R8: A write with `cfg_wr`=1 and `cfg_enable`=0 closes the channel at once. A request latched on the same edge, or a block already running, completes in full. `done` does not pulse unless that block was the last one.
- R9: After reset, `bus_req`, `rd_cyc`, `wr_cyc` and `done` are low and the channel is closed.
- R10: No read cycle starts while `bus_gnt` is low in the request state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle |
| cfg_enable | input | 1 | Value written: 1 opens, 0 closes the channel |
| cfg_blocks | input | CNT_W | Number of blocks to move, loaded by an enabling write |
| cfg_beats | input | LEN_W | Block length field L; a block has L+1 transfers |
| xfer_req_n | input | 1 | Raw active-low external transfer request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request, held until the last write of a block |
| rd_cyc | output | 1 | Source read cycle in progress |
| wr_cyc | output | 1 | Destination write cycle in progress |
| done | output | 1 | One-cycle pulse when the last block has completed |

## Verification
Two events can fall on the same rising edge: a disabling configuration write and the latch of a request. Both read the channel state that was present before the edge, so the request is still taken. The bench provokes this by placing the disable strobe on the edge where a freshly lowered request first reaches the synchronizer output. It then expects exactly one full block, no further activity while the pin stays low, and no `done`. A second collision, an enabling write that arrives mid-block, is judged by the total number of blocks and transfers once the original program has run out.

// File: rtl/dreq_pkg.sv
`timescale 1ns/1ps
package dreq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_BUSREQ,
        ST_READ,
        ST_WRITE,
        ST_DEAD
    } seq_state_t;

endpackage

// File: rtl/dreq_sync.sv
`timescale 1ns/1ps
module dreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_n,
    output logic q_n
);

    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d_n;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_n = chain[STAGES-1];

endmodule

// File: rtl/dreq_ctrl.sv
`timescale 1ns/1ps
module dreq_ctrl #(
    parameter int CNT_W = 8,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_enable,
    input  logic [CNT_W-1:0] cfg_blocks,
    input  logic [LEN_W-1:0] cfg_beats,
    input  logic             seq_idle,
    input  logic             blk_end,
    output logic             accept_en,
    output logic [LEN_W-1:0] beats_q,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] left_q;
    logic             last_blk;
    logic             set_ok;

    assign last_blk = (left_q == ONE);
    assign set_ok   = cfg_wr && cfg_enable && seq_idle && (cfg_blocks != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept_en <= 1'b0;
            left_q    <= '0;
            beats_q   <= '0;
            done      <= 1'b0;
        end else begin
            done <= blk_end && last_blk;
            if (set_ok) begin
                accept_en <= 1'b1;
                left_q    <= cfg_blocks;
                beats_q   <= cfg_beats;
            end else begin
                if (blk_end) begin
                    left_q <= left_q - ONE;
                    if (last_blk) accept_en <= 1'b0;
                end
                if (cfg_wr && !cfg_enable) accept_en <= 1'b0;
            end
        end
    end

    // R7: completion pulse lasts one cycle and leaves the channel closed
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_closed: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !accept_en);
    // R1: an enabling write with a zero count leaves a closed channel closed
    a_r1_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_enable && cfg_blocks == '0 && !accept_en) |=> !accept_en);
    // R8: a disabling write always closes the channel
    a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_enable) |=> !accept_en);

endmodule

// File: rtl/dreq_seq.sv
`timescale 1ns/1ps
module dreq_seq
    import dreq_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int CLR_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_en,
    input  logic             sync_req_n,
    input  logic [LEN_W-1:0] beats_q,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic             rd_cyc,
    output logic             wr_cyc,
    output logic             seq_idle,
    output logic             blk_end
);

    localparam int HOLD_W = (CLR_CYC > 1) ? $clog2(CLR_CYC) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(CLR_CYC - 1);

    seq_state_t       state, nxt;
    logic [HOLD_W-1:0] hcnt;
    logic [LEN_W-1:0]  beat;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept_en && !sync_req_n) nxt = ST_HOLD;
            ST_HOLD:   if (hcnt == HOLD_LAST) nxt = ST_BUSREQ;
            ST_BUSREQ: if (bus_gnt) nxt = ST_READ;
            ST_READ:   nxt = ST_WRITE;
            ST_WRITE:  nxt = (beat == beats_q) ? ST_DEAD : ST_READ;
            ST_DEAD:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hcnt  <= '0;
            beat  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_HOLD) hcnt <= hcnt + 1'b1;
            else                  hcnt <= '0;
            if (state == ST_BUSREQ)     beat <= '0;
            else if (state == ST_WRITE) beat <= beat + 1'b1;
        end
    end

    always_comb begin
        bus_req  = 1'b0;
        rd_cyc   = 1'b0;
        wr_cyc   = 1'b0;
        seq_idle = 1'b0;
        blk_end  = 1'b0;
        unique case (state)
            ST_IDLE:   seq_idle = 1'b1;
            ST_HOLD:   ;
            ST_BUSREQ: bus_req = 1'b1;
            ST_READ:   begin bus_req = 1'b1; rd_cyc = 1'b1; end
            ST_WRITE:  begin bus_req = 1'b1; wr_cyc = 1'b1; end
            ST_DEAD:   blk_end = 1'b1;
            default:   ;
        endcase
    end

    // R3: the bus is requested only after the clearance hold
    a_r3_busreq_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSREQ && $past(state) != ST_BUSREQ) |-> $past(state) == ST_HOLD);
    // R4: no latch while a block is requested, running or releasing
    a_r4_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req || blk_end) |=> state != ST_HOLD);
    // R5: every read is directly followed by its write
    a_r5_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cyc |=> wr_cyc);
    // R6: the final write is followed by a dead cycle with the bus released
    a_r6_dead_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cyc && beat == beats_q) |=> (!bus_req && blk_end));
    // R10: no read before the grant
    a_r10_wait_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSREQ && !bus_gnt) |=> !rd_cyc);

endmodule

// File: rtl/dreq_accept.sv
`timescale 1ns/1ps
module dreq_accept #(
    parameter int CNT_W       = 8,
    parameter int LEN_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CLR_CYC     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_enable,
    input  logic [CNT_W-1:0] cfg_blocks,
    input  logic [LEN_W-1:0] cfg_beats,
    input  logic             xfer_req_n,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic             rd_cyc,
    output logic             wr_cyc,
    output logic             done
);

    logic             sync_req_n;
    logic             accept_en;
    logic             seq_idle;
    logic             blk_end;
    logic [LEN_W-1:0] beats_q;

    dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d_n (xfer_req_n),
        .q_n (sync_req_n)
    );

    dreq_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_enable (cfg_enable),
        .cfg_blocks (cfg_blocks),
        .cfg_beats  (cfg_beats),
        .seq_idle   (seq_idle),
        .blk_end    (blk_end),
        .accept_en  (accept_en),
        .beats_q    (beats_q),
        .done       (done)
    );

    dreq_seq #(.LEN_W(LEN_W), .CLR_CYC(CLR_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_en  (accept_en),
        .sync_req_n (sync_req_n),
        .beats_q    (beats_q),
        .bus_gnt    (bus_gnt),
        .bus_req    (bus_req),
        .rd_cyc     (rd_cyc),
        .wr_cyc     (wr_cyc),
        .seq_idle   (seq_idle),
        .blk_end    (blk_end)
    );

    // R9: the block is quiet while reset is applied
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!bus_req && !rd_cyc && !wr_cyc));

endmodule

// File: tb/dreq_accept_bench.sv
`timescale 1ns/1ps
module dreq_accept_bench;

    localparam int CNT_W = 8;
    localparam int LEN_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic             cfg_enable = 1'b0;
    logic [CNT_W-1:0] cfg_blocks = '0;
    logic [LEN_W-1:0] cfg_beats = '0;
    logic             xfer_req_n = 1'b1;
    logic             bus_gnt = 1'b0;
    logic             bus_req, rd_cyc, wr_cyc, done;

    always #2 clk = ~clk;

    dreq_accept #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_dreq_accept (
        .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_enable (cfg_enable),
        .cfg_blocks (cfg_blocks), .cfg_beats (cfg_beats), .xfer_req_n (xfer_req_n),
        .bus_gnt (bus_gnt), .bus_req (bus_req), .rd_cyc (rd_cyc), .wr_cyc (wr_cyc),
        .done (done)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // grant model: grant after gnt_lat cycles of bus_req
    int gnt_lat = 0;
    int wcnt = 0;
    always @(negedge clk) begin
        if (!bus_req) begin
            bus_gnt <= 1'b0;
            wcnt    <= 0;
        end else if (wcnt >= gnt_lat) begin
            bus_gnt <= 1'b1;
        end else begin
            wcnt <= wcnt + 1;
        end
    end

    // monitor
    int     clr_tok = 0, seen_tok = 0;
    int     rd_n, wr_n, blk_n, done_n, alt_bad, gap_min, gap_max;
    bit     prev_rd, prev_bus, first_pend, wr_seen;
    longint last_wr;
    always @(negedge clk) begin
        if (clr_tok != seen_tok) begin
            seen_tok = clr_tok;
            rd_n = 0; wr_n = 0; blk_n = 0; done_n = 0; alt_bad = 0;
            gap_min = 100000; gap_max = 0; first_pend = 0; wr_seen = 0;
        end
        if (bus_req && !prev_bus) begin
            blk_n++;
            first_pend = 1;
        end
        if (rd_cyc) begin
            if (prev_rd) alt_bad++;
            rd_n++;
            if (first_pend) begin
                first_pend = 0;
                if (wr_seen) begin
                    if (int'(cyc - last_wr) < gap_min) gap_min = int'(cyc - last_wr);
                    if (int'(cyc - last_wr) > gap_max) gap_max = int'(cyc - last_wr);
                end
            end
        end
        if (wr_cyc) begin
            if (!prev_rd) alt_bad++;
            wr_n++;
            last_wr = cyc;
            wr_seen = 1;
        end
        if (rd_cyc && wr_cyc) alt_bad++;
        if (done) done_n++;
        prev_rd  = rd_cyc;
        prev_bus = bus_req;
    end

    function automatic int exp_xfers(int len, int blocks);
        return (len + 1) * blocks;
    endfunction

    function automatic int exp_gap(int lat);
        return 6 + lat;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        clr_tok++;
        @(negedge clk);
    endtask

    task automatic cfg(input bit en, input int blocks, input int beats);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_enable = en;
        cfg_blocks = CNT_W'(blocks); cfg_beats = LEN_W'(beats);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done) break;
        end
        @(negedge clk);
    endtask

    task automatic wait_bus(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (bus_req) break;
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        bit s_bus [1:6];
        bit s_rd  [1:6];
        int t;
        void'($urandom(32'h5eed_0d1a));

        // R9: reset state
        repeat (4) @(negedge clk);
        chk("R9 bus_req in reset", bus_req, 0);
        chk("R9 rd_cyc in reset", rd_cyc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 wr_cyc after reset", wr_cyc, 0);
        chk("R9 done after reset", done, 0);
        clear_mon();

        // R1: closed channel ignores a held request; sampling starts after enable
        xfer_req_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R1 no block while closed", blk_n, 0);
        clear_mon();
        cfg(1'b1, 2, 1);          // strobe at k=0, now at k=1
        repeat (2) @(negedge clk);
        chk("R1 bus_req k=3 after enable", bus_req, 0);
        @(negedge clk);
        chk("R1 bus_req k=4 after enable", bus_req, 1);
        wait_done(200);
        chk("R7 blocks run", blk_n, 2);
        chk("R5 reads", rd_n, exp_xfers(1, 2));
        chk("R5 writes", wr_n, exp_xfers(1, 2));
        chk("R5 alternation", alt_bad, 0);
        chk("R6 reopen gap", gap_min, exp_gap(0));
        chk("R7 done pulses", done_n, 1);
        repeat (20) @(negedge clk);
        chk("R7 no block after done", blk_n, 2);

        // R2/R3: latency from pin to bus request and first read
        xfer_req_n = 1'b1;
        repeat (4) @(negedge clk);
        cfg(1'b1, 1, 0);
        repeat (4) @(negedge clk);
        clear_mon();
        xfer_req_n = 1'b0;        // k=0
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            s_bus[k] = bus_req;
            s_rd[k]  = rd_cyc;
        end
        xfer_req_n = 1'b1;
        chk("R2 bus_req k=4", s_bus[4], 0);
        chk("R3 bus_req k=5", s_bus[5], 1);
        chk("R3 rd_cyc k=5", s_rd[5], 0);
        chk("R3 rd_cyc k=6", s_rd[6], 1);
        wait_done(100);
        chk("R5 single transfer", rd_n, 1);

        // R4: pin activity during a block is not queued; R1: enable write while busy ignored
        cfg(1'b1, 3, 3);
        clear_mon();
        xfer_req_n = 1'b0;
        wait_bus(50);
        xfer_req_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rd_cyc) break;
        end
        @(negedge clk);
        xfer_req_n = 1'b0;
        repeat (2) @(negedge clk);
        xfer_req_n = 1'b1;
        cfg(1'b1, 1, 7);
        repeat (40) @(negedge clk);
        chk("R4 one block only", blk_n, 1);
        chk("R4 reads of one block", rd_n, exp_xfers(3, 1));
        chk("R4 no done yet", done_n, 0);
        xfer_req_n = 1'b0;
        wait_done(300);
        xfer_req_n = 1'b1;
        chk("R1 busy enable ignored blocks", blk_n, 3);
        chk("R1 busy enable ignored reads", rd_n, exp_xfers(3, 3));
        chk("R7 done once", done_n, 1);

        // R8: disable on the same edge as the latch
        repeat (4) @(negedge clk);
        cfg(1'b1, 3, 2);
        clear_mon();
        xfer_req_n = 1'b0;        // k=0
        @(negedge clk);           // k=1
        cfg(1'b0, 0, 0);          // strobe at k=2, sampled with latch edge
        repeat (40) @(negedge clk);
        chk("R8 collision block", blk_n, 1);
        chk("R8 collision reads", rd_n, exp_xfers(2, 1));
        chk("R8 collision no done", done_n, 0);

        // R8: disable mid-block
        xfer_req_n = 1'b1;
        repeat (4) @(negedge clk);
        cfg(1'b1, 4, 5);
        clear_mon();
        xfer_req_n = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rd_cyc) break;
        end
        cfg(1'b0, 0, 0);
        repeat (40) @(negedge clk);
        chk("R8 midblock blocks", blk_n, 1);
        chk("R8 midblock writes", wr_n, exp_xfers(5, 1));
        chk("R8 midblock no done", done_n, 0);

        // R1: enabling write with zero count
        clear_mon();
        cfg(1'b1, 0, 3);
        repeat (20) @(negedge clk);
        chk("R1 zero count ignored", blk_n, 0);

        // R10: slow grant
        xfer_req_n = 1'b1;
        repeat (4) @(negedge clk);
        gnt_lat = 5;
        cfg(1'b1, 1, 0);
        clear_mon();
        xfer_req_n = 1'b0;
        wait_bus(50);
        t = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (rd_cyc) begin t = i; break; end
        end
        chk("R10 read waits for grant", t, 6);
        xfer_req_n = 1'b1;
        wait_done(100);

        // random programs with held request
        for (int it = 0; it < 10; it++) begin
            int l, c, g;
            l = int'($urandom_range(0, 7));
            c = int'($urandom_range(1, 4));
            g = int'($urandom_range(0, 3));
            xfer_req_n = 1'b1;
            repeat (4) @(negedge clk);
            clear_mon();
            gnt_lat = g;
            cfg(1'b1, c, l);
            xfer_req_n = 1'b0;
            wait_done(3000);
            xfer_req_n = 1'b1;
            chk("R5 random reads", rd_n, exp_xfers(l, c));
            chk("R5 random writes", wr_n, exp_xfers(l, c));
            chk("R7 random blocks", blk_n, c);
            chk("R7 random done", done_n, 1);
            chk("R5 random alternation", alt_bad, 0);
            if (c > 1) begin
                chk("R6 random gap min", gap_min, exp_gap(g));
                chk("R6 random gap max", gap_max, exp_gap(g));
            end
        end

        finish_run();
    end

endmodule